// File: doc/BRIEF.md
# Bit-Counted Serial Command Receiver

This block is the receive side of a write-only serial port for a multi-channel converter. It watches three pins: an active-low frame strobe `sync_n`, a serial clock `sclk` and a data line `din`. All three are oversampled on a faster system clock. The block turns them into fixed-length 24-bit command words. Each finished word is presented on `word` together with a one-cycle `word_valid` pulse, for the register logic downstream.

A frame is bounded by the bit count alone. A falling edge of `sync_n` arms the port and zeroes the bit count. From then on every falling `sclk` edge shifts one `din` bit in, most significant bit first. This goes on until 24 bits have arrived, whatever `sync_n` does apart from falling again. Once the word is complete, `sclk` is ignored until the next falling edge of `sync_n`.

One consequence matters on boards where several ports share `sclk` and `din`. A stray low glitch on one port's strobe leaves that port armed. That port then takes the next 24 bits on the shared lines, even if they arrive much later.

Top module: `dac_serial_rx`

## Requirements
- R1: Bits are captured on falling `sclk` edges only and shifted in most significant bit first. The first bit of a frame lands in `word[23]` and the 24th in `word[0]`. Rising `sclk` edges shift nothing.
- R2: `word_valid` is high for exactly one system clock cycle per completed frame. `word` changes only in that cycle (or on reset) and holds its value otherwise.
- R3: A port that has not been armed by a `sync_n` falling edge ignores `sclk` and `din`: no `word_valid` and no change of `word`.
- R4: A rising edge of `sync_n` before the 24th bit neither aborts nor completes the frame. The remaining bits are still collected, and the word completes after bit 24.
- R5: After the 24th bit, further `sclk` falling edges are ignored until the next `sync_n` falling edge: no extra pulse and no change of `word`.
- R6: A `sync_n` low pulse one system clock long arms the port. Bits clocked in later, after any delay, form that frame while `sync_n` stays high.
- R7: A `sync_n` falling edge in the middle of a frame discards the partial word and starts counting from zero again.
- R8: A `sync_n` high interval one system clock long between two low periods is recognised as a new frame start.
- R9: `rst` (synchronous, active high) or the hardware reset `hw_rst_n` (active low, synchronised inside) clears `word` to zero and `word_valid` to low. It also drops any frame in progress, so the bits that follow without a new falling edge are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, fast enough to see every `sclk` level |
| rst | input | 1 | Synchronous active-high system reset |
| hw_rst_n | input | 1 | Asynchronous active-low hardware reset pin |
| sync_n | input | 1 | Active-low frame strobe pin |
| sclk | input | 1 | Serial clock pin, idle high |
| din | input | 1 | Serial data pin |
| word | output | 24 | Last completed command word |
| word_valid | output | 1 | One-cycle strobe marking a newly completed word |

## Verification
The bench goes after the framing corner cases. A design that ends the frame on a rising `sync_n` would drop the mid-frame-release words. A design that needs the strobe held low would miss the word after a one-cycle arming pulse and a 3000-cycle gap. One that keeps counting past 24 would raise a second strobe on trailing clocks. The bench also sends an unarmed burst, restarts a frame with a one-cycle high gap, and applies both resets in the middle of a frame. A receiver that captured without arming, kept stale partial bits, or did not clear its frame state on reset would report a wrong word or a wrong number of strobes.

// File: rtl/dac_rx_pkg.sv
package dac_rx_pkg;
  // Default command length and synchronizer depth for the serial receiver.
  localparam int unsigned RX_WORD_W   = 24;
  localparam int unsigned RX_STAGES   = 2;

  // Pin positions inside the synchronized input bundle.
  localparam int unsigned PIN_SYNC = 0;
  localparam int unsigned PIN_SCLK = 1;
  localparam int unsigned PIN_DIN  = 2;
  localparam int unsigned PIN_HWR  = 3;
  localparam int unsigned PIN_CNT  = 4;

  // Idle levels: strobe high, clock high, data low, hardware reset released.
  localparam logic [PIN_CNT-1:0] PIN_IDLE = 4'b1011;
endpackage

// File: rtl/dac_rx_sync.sv
module dac_rx_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  // One flop chain per pin, each reset to that pin's idle level.
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[g]}};
      else     chain <= {chain[STAGES-2:0], d_in[g]};
    end
    assign d_out[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/dac_rx_edge.sv
module dac_rx_edge #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] fall
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= RST_VAL;
    else     lvl_q <= lvl;
  end

  // A high-to-low step between consecutive samples.
  assign fall = lvl_q & ~lvl;
endmodule

// File: rtl/dac_rx_frame.sv
module dac_rx_frame #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              sync_fall,
  input  logic              sclk_fall,
  input  logic              din,
  output logic [WORD_W-1:0] word,
  output logic              word_valid
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              armed;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-2:0] shreg;

  always_ff @(posedge clk) begin
    if (clr) begin
      armed      <= 1'b0;
      cnt        <= '0;
      shreg      <= '0;
      word       <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (sync_fall) begin
        // A new strobe edge always wins: restart the count.
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed && sclk_fall) begin
        shreg <= {shreg[WORD_W-3:0], din};
        if (cnt == LAST) begin
          armed      <= 1'b0;
          cnt        <= '0;
          word       <= {shreg, din};
          word_valid <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dac_serial_rx.sv
module dac_serial_rx
  import dac_rx_pkg::*;
#(
  parameter int unsigned WORD_W = RX_WORD_W,
  parameter int unsigned STAGES = RX_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_rst_n,
  input  logic              sync_n,
  input  logic              sclk,
  input  logic              din,
  output logic [WORD_W-1:0] word,
  output logic              word_valid
);
  logic [PIN_CNT-1:0] pins_raw;
  logic [PIN_CNT-1:0] pins_s;
  logic [1:0]         falls;
  logic               sync_fall;
  logic               sclk_fall;
  logic               clr;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_SYNC] = sync_n;
    pins_raw[PIN_SCLK] = sclk;
    pins_raw[PIN_DIN]  = din;
    pins_raw[PIN_HWR]  = hw_rst_n;
  end

  dac_rx_sync #(
    .W(PIN_CNT), .STAGES(STAGES), .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk(clk), .rst(rst), .d_in(pins_raw), .d_out(pins_s)
  );

  dac_rx_edge #(
    .W(2), .RST_VAL(2'b11)
  ) u_edge (
    .clk(clk), .rst(rst),
    .lvl({pins_s[PIN_SCLK], pins_s[PIN_SYNC]}),
    .fall(falls)
  );

  assign sync_fall = falls[0];
  assign sclk_fall = falls[1];
  assign clr       = rst | ~pins_s[PIN_HWR];

  dac_rx_frame #(
    .WORD_W(WORD_W)
  ) u_frame (
    .clk(clk), .clr(clr),
    .sync_fall(sync_fall), .sclk_fall(sclk_fall),
    .din(pins_s[PIN_DIN]),
    .word(word), .word_valid(word_valid)
  );
endmodule

// File: rtl/dac_rx_chk.sv
module dac_rx_chk #(
  parameter int unsigned WORD_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              clr,
  input logic              sync_fall,
  input logic              sclk_fall,
  input logic [WORD_W-1:0] word,
  input logic              word_valid
);
  localparam int unsigned SEEN_W = $clog2(WORD_W) + 1;

  // Independent tally of clock falls since the latest strobe fall.
  logic [SEEN_W-1:0] seen;
  logic              rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst || sync_fall)             seen <= '0;
    else if (sclk_fall && !(&seen))   seen <= seen + 1'b1;
  end

  p_pulse_r2: assert property (@(posedge clk) disable iff (clr)
    word_valid |=> !word_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (clr)
    !$stable(word) |-> word_valid);

  p_len_r4: assert property (@(posedge clk) disable iff (clr)
    word_valid |-> seen == SEEN_W'(WORD_W));

  p_edge_r1: assert property (@(posedge clk) disable iff (clr)
    word_valid |-> $past(sclk_fall));

  always @(posedge clk) begin
    if (rst_q) begin
      p_clear_r9: assert (!word_valid && word == '0);
    end
  end
endmodule

bind dac_serial_rx dac_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .clr(clr),
  .sync_fall(sync_fall), .sclk_fall(sclk_fall),
  .word(word), .word_valid(word_valid)
);

// File: tb/test_dac_serial_rx.sv
module test_dac_serial_rx;
  localparam int W = 24;
  localparam int H = 4;
  localparam int NV = 6;
  // {mode, data}: 0 plain, 1 strobe released mid-frame, 2 short arm pulse, 3 trailing clocks
  localparam logic [W+1:0] VEC [NV] = '{
    {2'd0, 24'hA5C30F}, {2'd0, 24'h800001}, {2'd1, 24'h3C5A96},
    {2'd2, 24'hF00F11}, {2'd3, 24'h7E8124}, {2'd1, 24'h000FFF}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, hw_rst_n, sync_n, sclk, din;
  logic [W-1:0] word;
  logic word_valid;
  int n_chk = 0, n_bad = 0, n_valid = 0;
  bit done = 0;

  dac_serial_rx i_dac_serial_rx (
    .clk(clk), .rst(rst), .hw_rst_n(hw_rst_n), .sync_n(sync_n),
    .sclk(sclk), .din(din), .word(word), .word_valid(word_valid)
  );

  always @(posedge clk) if (word_valid) n_valid <= n_valid + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    din = b; idle(H); sclk = 1'b0; idle(H); sclk = 1'b1;
  endtask

  task automatic bits(input logic [W-1:0] v, input int from, input int to);
    for (int i = from; i < to; i++) bit_out(v[W-1-i]);
  endtask

  task automatic frame(input logic [W-1:0] v, input logic [1:0] mode);
    case (mode)
      2'd0: begin sync_n = 0; idle(2); bits(v, 0, W); idle(2); sync_n = 1; end
      2'd1: begin sync_n = 0; idle(2); bits(v, 0, 8); sync_n = 1; bits(v, 8, W); end
      2'd2: begin sync_n = 0; idle(1); sync_n = 1; idle(50); bits(v, 0, W); end
      default: begin
        sync_n = 0; idle(2); bits(v, 0, W);
        for (int i = 0; i < 5; i++) bit_out(1'b1);
        sync_n = 1;
      end
    endcase
    idle(12);
  endtask

  function automatic string req_of(input logic [1:0] mode);
    case (mode)
      2'd0: return "R1";
      2'd1: return "R4";
      2'd2: return "R6";
      default: return "R5";
    endcase
  endfunction

  initial begin
    int base;
    rst = 1; hw_rst_n = 1; sync_n = 1; sclk = 1; din = 0;
    idle(5); rst = 0; idle(3);
    chk("R9 reset word", word, 0);
    chk("R9 reset valid", word_valid, 0);

    // R3: bits with no strobe edge are ignored
    base = n_valid;
    bits(24'hFFFFFF, 0, W); idle(12);
    chk("R3 unarmed pulses", n_valid - base, 0);
    chk("R3 unarmed word", word, 0);

    for (int k = 0; k < NV; k++) begin
      base = n_valid;
      frame(VEC[k][W-1:0], VEC[k][W+1:W]);
      chk({req_of(VEC[k][W+1:W]), " pulses"}, n_valid - base, 1);
      chk({req_of(VEC[k][W+1:W]), " word"}, word, VEC[k][W-1:0]);
    end

    // R5: clocks after completion with strobe high change nothing
    base = n_valid;
    bits(24'hABCDEF, 0, 10); idle(12);
    chk("R5 extra clocks pulses", n_valid - base, 0);
    chk("R5 extra clocks word", word, VEC[NV-1][W-1:0]);

    // R7 / R8: mid-frame restart through a one-cycle high gap
    base = n_valid;
    sync_n = 0; idle(2); bits(24'h123456, 0, 10);
    sync_n = 1; idle(1); sync_n = 0; idle(2);
    bits(24'h654321, 0, W); sync_n = 1; idle(12);
    chk("R7 restart pulses", n_valid - base, 1);
    chk("R8 short high gap word", word, 24'h654321);

    // R6: one-cycle arm pulse, long wait, then bits
    base = n_valid;
    sync_n = 0; idle(1); sync_n = 1; idle(3000);
    bits(24'h0F1E2D, 0, W); idle(12);
    chk("R6 late bits pulses", n_valid - base, 1);
    chk("R6 late bits word", word, 24'h0F1E2D);

    // R9: hardware reset in the middle of a frame
    base = n_valid;
    sync_n = 0; idle(2); bits(24'hDEADBE, 0, 12);
    hw_rst_n = 0; idle(6);
    chk("R9 hw reset word", word, 0);
    hw_rst_n = 1; idle(4);
    bits(24'hDEADBE, 12, W); sync_n = 1; idle(12);
    chk("R9 hw reset drops frame", n_valid - base, 0);
    chk("R9 hw reset word stays", word, 0);

    frame(24'h13579B, 2'd0);
    chk("R1 after hw reset", word, 24'h13579B);

    // R9: system reset in the middle of a frame
    base = n_valid;
    sync_n = 0; idle(2); bits(24'h2468AC, 0, 12);
    rst = 1; idle(2);
    chk("R9 rst word", word, 0);
    chk("R9 rst valid", word_valid, 0);
    sync_n = 1; rst = 0; idle(4);
    bits(24'h2468AC, 12, W); idle(12);
    chk("R9 rst drops frame", n_valid - base, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule